// File: doc/BRIEF.md
# T1 Remote Alarm Detector

This block watches a received T1 stream and raises a remote-alarm indication when the far end signals that it has lost the near-end signal. It recognises three different encodings of that indication. The framing mode and a format bit choose which encoding is active. In extended-superframe mode, the indication is a repeating pattern carried on the data link. In superframe mode, it is either a zero forced into bit 2 of every channel, or a one placed in the signalling bit of frame 12.

An external frame counter supplies the position strobes. The block assumes these strobes are correct, one system clock per qualified bit. Extraction of the data-link bits is also done outside; those bits arrive with their own valid strobe. The block drives a live alarm level and a sticky status bit. The host clears the sticky bit with a read strobe.

All detectors use the system clock. A detector result appears on the outputs right after the clock edge that samples the deciding bit. The asynchronous reset is released synchronously inside the block, two clocks after the pin is released.

Top module: `t1_yellow_detect`

## Requirements
- R1: With `mode_esf`=1, `yel_alarm` rises on the clock edge that samples the last bit of the 16th consecutive, aligned repetition of a 16-bit pattern on `dl_bit` (sampled only where `dl_valid`=1). The pattern is eight 0 bits followed by eight 1 bits, in arrival order. After 15 repetitions plus 15 bits, the output is still low.
- R2: In extended-superframe mode, once the pattern has been found, each following 16-bit period is checked at its last bit. A period that is not the pattern clears `yel_alarm` on that bit and restarts the repetition count from zero.
- R3: Cycles with `dl_valid`=0 leave the extended-superframe detector unchanged, whatever `dl_bit` is.
- R4: With `mode_esf`=0 and `s12_fmt`=0, every cycle with `bit2_stb`=1 samples `rx_data` as bit 2 of a channel. `yel_alarm` rises on the 256th consecutive such sample equal to 0 and stays low after 255. Cycles with `bit2_stb`=0 are ignored.
- R5: In the channel-bit format, a bit-2 sample equal to 1 clears `yel_alarm` and resets the zero count to zero.
- R6: With `mode_esf`=0 and `s12_fmt`=1, a cycle with both `fbit_stb`=1 and `frame12`=1 sets `yel_alarm` to the value of `rx_data`. Signalling bits of other frames, and non-framing bits, leave it unchanged.
- R7: `yel_alarm` reflects only the detector chosen by the mode inputs. The detectors that are not chosen are held cleared (counts and alarm) for as long as they are deselected.
- R8: `yel_sticky` is set one clock after `yel_alarm` is high and stays set after the alarm falls. It clears on a cycle with `rd_clr`=1 only if `yel_alarm` is low in that cycle.
- R9: `soft_rst`=1 clears both outputs and all counts at the next clock edge. `rst_n`=0 clears them at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_rst | input | 1 | Synchronous clear of all state |
| mode_esf | input | 1 | 1 = extended-superframe, 0 = superframe |
| s12_fmt | input | 1 | Superframe alarm format: 0 = channel bit 2, 1 = frame-12 signalling bit |
| rx_data | input | 1 | Received serial data bit |
| bit2_stb | input | 1 | Current `rx_data` is bit 2 of a channel |
| fbit_stb | input | 1 | Current `rx_data` is a framing/signalling bit |
| frame12 | input | 1 | Current frame is frame 12 of the superframe |
| dl_bit | input | 1 | Data-link bit |
| dl_valid | input | 1 | `dl_bit` is valid this cycle |
| rd_clr | input | 1 | Host read strobe that clears the sticky bit |
| yel_alarm | output | 1 | Live remote-alarm level |
| yel_sticky | output | 1 | Latched remote-alarm status |

## Verification
The bench drives the pattern detector to exactly 255 and 256 pattern bits. A design that is off by one repetition, or that checks periods at the wrong phase, fails there. It then breaks one period partway through a count. A design that keeps the earlier repetitions would raise the alarm 80 bits early. In the channel-bit format, it checks the 255/256 boundary again, adds a single one partway through, and mixes in non-bit-2 ones that must be ignored. It switches mode partway through a count and then leaves 100 zeros short of the threshold, so a design that does not clear deselected detectors would alarm. The frame-12 tests and the host read strobe, issued while the alarm is high and while it is low, catch a sticky bit that clears unconditionally or follows the wrong frame.

// File: rtl/yel_pkg.sv
package yel_pkg;

  typedef enum logic [1:0] {
    SRC_LINK    = 2'd0,
    SRC_CHANBIT = 2'd1,
    SRC_FRAME12 = 2'd2
  } yel_src_e;

  function automatic yel_src_e yel_pick(input logic esf, input logic s12);
    if (esf)      return SRC_LINK;
    else if (s12) return SRC_FRAME12;
    else          return SRC_CHANBIT;
  endfunction

endpackage

// File: rtl/yel_rst_sync.sv
module yel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/yel_link_det.sv
module yel_link_det #(
  parameter int PAT_W = 16,
  parameter int REPS  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic dl_bit,
  input  logic dl_valid,
  output logic alarm
);

  localparam int HALF  = PAT_W / 2;
  localparam int PH_W  = $clog2(PAT_W);
  localparam int REP_W = $clog2(REPS + 1);
  localparam logic [PAT_W-1:0] PAT = {{HALF{1'b0}}, {HALF{1'b1}}};

  logic [PAT_W-1:0] win_q, win_d, win_sh;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             alm_q, alm_d;
  logic             hit;

  assign win_sh = {win_q[PAT_W-2:0], dl_bit};
  assign hit    = (win_sh == PAT);

  // next state
  always_comb begin
    win_d = win_q;
    ph_d  = ph_q;
    rep_d = rep_q;
    alm_d = alm_q;
    if (clr) begin
      win_d = '0;
      ph_d  = '0;
      rep_d = '0;
      alm_d = 1'b0;
    end else if (dl_valid) begin
      win_d = win_sh;
      if (rep_q == '0) begin
        // hunting for pattern alignment
        if (hit) begin
          rep_d = REP_W'(1);
          ph_d  = '0;
          alm_d = alm_q | (REP_W'(1) == REP_W'(REPS));
        end
      end else if (ph_q == PH_W'(PAT_W - 1)) begin
        ph_d = '0;
        if (hit) begin
          rep_d = (rep_q == REP_W'(REPS)) ? rep_q : rep_q + REP_W'(1);
          alm_d = alm_q | (rep_d == REP_W'(REPS));
        end else begin
          rep_d = '0;
          alm_d = 1'b0;
        end
      end else begin
        ph_d = ph_q + PH_W'(1);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      ph_q  <= '0;
      rep_q <= '0;
      alm_q <= 1'b0;
    end else begin
      win_q <= win_d;
      ph_q  <= ph_d;
      rep_q <= rep_d;
      alm_q <= alm_d;
    end
  end

  assign alarm = alm_q;

  p_rep_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rep_q <= REP_W'(REPS));

  p_rise_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_q) |-> (rep_q == REP_W'(REPS)));

  p_fall_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alm_q) |-> (rep_q == '0));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !dl_valid) |=> ($stable(alm_q) && $stable(rep_q) && $stable(ph_q)));

  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!alm_q && rep_q == '0));

endmodule

// File: rtl/yel_chan_det.sv
module yel_chan_det #(
  parameter int THRESH = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic b2_stb,
  input  logic rx,
  output logic alarm
);

  localparam int CW = $clog2(THRESH + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          alm_q, alm_d;

  always_comb begin
    cnt_d = cnt_q;
    alm_d = alm_q;
    if (clr) begin
      cnt_d = '0;
      alm_d = 1'b0;
    end else if (b2_stb) begin
      if (rx) begin
        cnt_d = '0;
        alm_d = 1'b0;
      end else begin
        if (cnt_q != CW'(THRESH)) cnt_d = cnt_q + CW'(1);
        if (cnt_d == CW'(THRESH)) alm_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      alm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      alm_q <= alm_d;
    end
  end

  assign alarm = alm_q;

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(THRESH));

  p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_q) |-> (cnt_q == CW'(THRESH)));

  p_one_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && b2_stb && rx) |=> (!alm_q && cnt_q == '0));

  p_other_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !b2_stb) |=> ($stable(cnt_q) && $stable(alm_q)));

endmodule

// File: rtl/yel_s12_det.sv
module yel_s12_det (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic f_stb,
  input  logic f12,
  input  logic rx,
  output logic alarm
);

  logic alm_q, alm_d;
  logic take;

  assign take = f_stb & f12;

  always_comb begin
    alm_d = alm_q;
    if (clr)       alm_d = 1'b0;
    else if (take) alm_d = rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alm_q <= 1'b0;
    else        alm_q <= alm_d;
  end

  assign alarm = alm_q;

  p_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && f_stb && f12) |=> (alm_q == $past(rx)));

  p_other_frames_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(f_stb && f12)) |=> $stable(alm_q));

endmodule

// File: rtl/yel_sticky.sv
module yel_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic alarm,
  input  logic rd_clr,
  output logic sticky
);

  logic stk_q, stk_d;

  always_comb begin
    if (clr) stk_d = 1'b0;
    else     stk_d = alarm | (stk_q & ~rd_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stk_q <= 1'b0;
    else        stk_q <= stk_d;
  end

  assign sticky = stk_q;

  p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && alarm) |=> stk_q);

  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && stk_q && !rd_clr) |=> stk_q);

  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !alarm) |=> !stk_q);

endmodule

// File: rtl/t1_yellow_detect.sv
module t1_yellow_detect
  import yel_pkg::*;
#(
  parameter int PAT_W      = 16,
  parameter int REPS       = 16,
  parameter int THRESH     = 256,
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic mode_esf,
  input  logic s12_fmt,
  input  logic rx_data,
  input  logic bit2_stb,
  input  logic fbit_stb,
  input  logic frame12,
  input  logic dl_bit,
  input  logic dl_valid,
  input  logic rd_clr,
  output logic yel_alarm,
  output logic yel_sticky
);

  logic     rst_n_s;
  yel_src_e src;
  logic     clr_link, clr_chan, clr_s12;
  logic     alm_link, alm_chan, alm_s12;
  logic     alm_sel;

  yel_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_s)
  );

  assign src      = yel_pick(mode_esf, s12_fmt);
  assign clr_link = soft_rst | (src != SRC_LINK);
  assign clr_chan = soft_rst | (src != SRC_CHANBIT);
  assign clr_s12  = soft_rst | (src != SRC_FRAME12);

  yel_link_det #(.PAT_W(PAT_W), .REPS(REPS)) u_link (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr      (clr_link),
    .dl_bit   (dl_bit),
    .dl_valid (dl_valid),
    .alarm    (alm_link)
  );

  yel_chan_det #(.THRESH(THRESH)) u_chan (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (clr_chan),
    .b2_stb (bit2_stb),
    .rx     (rx_data),
    .alarm  (alm_chan)
  );

  yel_s12_det u_s12 (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (clr_s12),
    .f_stb (fbit_stb),
    .f12   (frame12),
    .rx    (rx_data),
    .alarm (alm_s12)
  );

  always_comb begin
    unique case (src)
      SRC_LINK:    alm_sel = alm_link;
      SRC_CHANBIT: alm_sel = alm_chan;
      SRC_FRAME12: alm_sel = alm_s12;
      default:     alm_sel = 1'b0;
    endcase
  end

  assign yel_alarm = alm_sel;

  yel_sticky u_stk (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (soft_rst),
    .alarm  (alm_sel),
    .rd_clr (rd_clr),
    .sticky (yel_sticky)
  );

  p_one_source_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    $countones({alm_link, alm_chan, alm_s12}) <= 1 || $past(soft_rst) == 1'b0);

  p_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (src != SRC_LINK) |=> !alm_link);

  p_soft_rst_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    soft_rst |=> (!alm_link && !alm_chan && !alm_s12 && !yel_sticky));

endmodule

// File: tb/t1_yellow_detect_bench.sv
module t1_yellow_detect_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, soft_rst, mode_esf, s12_fmt, rx_data, bit2_stb, fbit_stb;
  logic frame12, dl_bit, dl_valid, rd_clr;
  logic yel_alarm, yel_sticky;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    bit    is_stk;
    logic  exp;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  t1_yellow_detect u_t1_yellow_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .mode_esf   (mode_esf),
    .s12_fmt    (s12_fmt),
    .rx_data    (rx_data),
    .bit2_stb   (bit2_stb),
    .fbit_stb   (fbit_stb),
    .frame12    (frame12),
    .dl_bit     (dl_bit),
    .dl_valid   (dl_valid),
    .rd_clr     (rd_clr),
    .yel_alarm  (yel_alarm),
    .yel_sticky (yel_sticky)
  );

  // monitor: compares queued expectations with the outputs
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb_q.size() > 0) begin
        exp_t e;
        logic act;
        e   = sb_q.pop_front();
        act = e.is_stk ? yel_sticky : yel_alarm;
        checks++;
        if (act !== e.exp) begin
          errors++;
          $display("FAIL %s %s: actual=%b expected=%b", e.tag,
                   e.is_stk ? "yel_sticky" : "yel_alarm", act, e.exp);
        end
      end
    end
  end

  task automatic exp_a(input logic v, input string tag);
    exp_t e;
    e.is_stk = 1'b0; e.exp = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic exp_s(input logic v, input string tag);
    exp_t e;
    e.is_stk = 1'b1; e.exp = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic quiet();
    soft_rst = 0; rx_data = 0; bit2_stb = 0; fbit_stb = 0;
    frame12 = 0; dl_bit = 0; dl_valid = 0; rd_clr = 0;
  endtask

  task automatic tk();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); quiet(); rx_data = 1; dl_bit = i[0]; tk();
    end
  endtask

  task automatic dl_send(input logic b);
    @(negedge clk); quiet(); dl_bit = b; dl_valid = 1; tk();
  endtask

  task automatic dl_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) dl_send(b[i]);
  endtask

  task automatic dl_rep(input int n);
    for (int i = 0; i < n; i++) begin dl_byte(8'h00); dl_byte(8'hFF); end
  endtask

  task automatic chan(input logic v);
    @(negedge clk); quiet(); rx_data = v; bit2_stb = 1; tk();
  endtask

  task automatic chan_zeros(input int n);
    for (int i = 0; i < n; i++) begin
      chan(1'b0);
      if (i % 50 == 49) idle(1);   // non-bit-2 ones, must be ignored
    end
  endtask

  task automatic sbit(input logic f12v, input logic v);
    @(negedge clk); quiet(); fbit_stb = 1; frame12 = f12v; rx_data = v; tk();
  endtask

  task automatic host_read();
    @(negedge clk); quiet(); rd_clr = 1; tk();
  endtask

  task automatic set_mode(input logic esf, input logic s12);
    @(negedge clk); quiet(); mode_esf = esf; s12_fmt = s12; tk();
  endtask

  task automatic finish_run();
    @(posedge clk);
    #3;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode_esf = 1; s12_fmt = 0;
    quiet();
    repeat (4) @(negedge clk);
    exp_a(0, "R9 reset"); exp_s(0, "R9 reset");
    @(negedge clk); rst_n = 1;
    idle(4);
    exp_a(0, "R9 after reset"); exp_s(0, "R9 after reset");

    // ---- R1 extended-superframe pattern count
    dl_rep(15);
    dl_byte(8'h00);
    for (int i = 0; i < 7; i++) dl_send(1'b1);
    exp_a(0, "R1 255 bits");
    dl_send(1'b1);
    exp_a(1, "R1 256 bits");

    // ---- R3 invalid link cycles ignored
    idle(20);
    exp_a(1, "R3 dl_valid low");
    exp_s(1, "R8 set");

    // ---- R8 read while alarm high keeps sticky
    host_read();
    exp_s(1, "R8 read while alarm");

    // ---- R2 non-pattern period clears
    for (int i = 0; i < 15; i++) dl_send(1'b1);
    exp_a(1, "R2 15 bad bits");
    dl_send(1'b1);
    exp_a(0, "R2 bad period");
    exp_s(1, "R8 sticky after fall");
    host_read();
    exp_s(0, "R8 read clears");

    // ---- R2 broken period restarts count
    dl_rep(5);
    dl_byte(8'h00); dl_byte(8'h7F);
    dl_rep(15);
    dl_byte(8'h00);
    for (int i = 0; i < 7; i++) dl_send(1'b1);
    exp_a(0, "R2 restart 255");
    dl_send(1'b1);
    exp_a(1, "R2 restart 256");

    // ---- R7 mode switch clears deselected detector
    set_mode(0, 0);
    exp_a(0, "R7 switch to chanbit");
    set_mode(1, 0);
    exp_a(0, "R7 link cleared");
    host_read();

    // ---- R4 / R5 channel bit-2 format
    set_mode(0, 0);
    chan_zeros(255);
    exp_a(0, "R4 255 zeros");
    chan(1'b0);
    exp_a(1, "R4 256 zeros");
    chan(1'b1);
    exp_a(0, "R5 one clears");
    chan_zeros(200);
    chan(1'b1);
    chan_zeros(255);
    exp_a(0, "R5 count restarted");
    chan(1'b0);
    exp_a(1, "R4 after restart");
    chan(1'b1);
    chan_zeros(200);
    set_mode(0, 1);
    set_mode(0, 0);
    chan_zeros(100);
    exp_a(0, "R7 chan count cleared");
    host_read();
    exp_s(0, "R8 cleared before s12");

    // ---- R6 frame-12 signalling bit
    set_mode(0, 1);
    exp_a(0, "R6 start");
    sbit(1'b0, 1'b1);
    exp_a(0, "R6 other frame");
    sbit(1'b1, 1'b1);
    exp_a(1, "R6 frame12 one");
    sbit(1'b0, 1'b0);
    exp_a(1, "R6 other frame zero");
    @(negedge clk); quiet(); frame12 = 1; rx_data = 0; tk();
    exp_a(1, "R6 non-framing bit");
    sbit(1'b1, 1'b0);
    exp_a(0, "R6 frame12 zero");
    exp_s(1, "R8 s12 sticky");
    host_read();
    exp_s(0, "R8 s12 read");

    // ---- R9 synchronous and asynchronous reset
    sbit(1'b1, 1'b1);
    idle(1);
    exp_s(1, "R9 pre soft");
    @(negedge clk); quiet(); soft_rst = 1; tk();
    exp_a(0, "R9 soft alarm"); exp_s(0, "R9 soft sticky");
    sbit(1'b1, 1'b1);
    idle(1);
    @(negedge clk); rst_n = 0;
    #1;
    exp_a(0, "R9 async alarm"); exp_s(0, "R9 async sticky");
    @(negedge clk); rst_n = 1;
    done = 1'b1;
    finish_run();
  end

endmodule